// File: doc/BRIEF.md
# DRAM Refresh Scheduler (CAS-before-RAS with RAS-only Variant)

This block keeps an asynchronous DRAM refreshed for the access sequencer that shares its strobe pins. After reset it lets a start-up delay expire and then runs a fixed number of initialisation refresh cycles. Once those are done it owes one refresh per interval, where the interval is the refresh period divided by the number of rows. It asks for the pins with `ref_req`. The access sequencer answers with `ref_gnt` when the pins are free. On a grant the block drives RAS, CAS and WE for one complete refresh cycle and then returns the pins.

The default variant refreshes with CAS leading RAS. The DRAM uses its internal row counter for this, so the address lines stay at zero. The alternative variant, chosen by parameter, keeps CAS high and drives RAS with a row taken from its own wrapping row counter. Intervals that pass without a grant are recorded in a saturating debt counter and paid back one after another. A self-refresh command holds both strobes low for as long as it is asserted, with a minimum hold time. On exit the strobes are held high for a recovery time before the pins are released.

Top module: `dram_rfsh_sched`

## Requirements
- R1: While reset is asserted and for STARTUP_CYC cycles after it is released, `ref_req` is low, `init_done` is low, `ras_n`, `cas_n` and `we_n` are high, and `addr` is zero.
- R2: After the start-up delay, exactly INIT_REFS refresh cycles complete before `init_done` rises. `init_done` goes high in the cycle after the last of them ends.
- R3: `ref_req` stays high until a cycle in which `ref_gnt` is high. While `ref_req` is high, `ras_n` and `cas_n` stay high. The strobe sequence starts in the cycle after the grant.
- R4: A CAS-before-RAS refresh drives `cas_n` low for CSR_CYC cycles with `ras_n` high, then drives `ras_n` low for RAS_CYC cycles. `cas_n` stays low for the first CHR_CYC of those cycles. All strobes are then high for RP_CYC cycles. `we_n` is high throughout.
- R5: Once `init_done` is high, one refresh becomes owed every IVL_CYC = REF_PERIOD_US*CLK_MHZ/2^ROW_W cycles. An owed refresh raises `ref_req` in the cycle after the block returns to idle.
- R6: Owed refreshes that have not been granted accumulate up to DEBT_MAX. Further intervals are dropped. Each completed refresh pays back one.
- R7: With RAS_ONLY=1, `cas_n` never goes low during refresh. `addr` carries the row counter while `ras_n` is low. The counter advances by one per refresh, starting at 0.
- R8: The RAS-only row counter wraps from 2^ROW_W-1 (2047 by default) to 0.
- R9: When idle with nothing owed and `init_done` high, a high `sr_req` raises `ref_req`. After the grant, `cas_n` is low for CSR_CYC cycles before `ras_n` falls. Both strobes then stay low, with `sr_active` high, for at least RASS_CYC cycles and for as long as `sr_req` stays high.
- R10: On self-refresh exit, all strobes are high for RPS_CYC cycles before the block can request again. The refresh debt is cleared at the end of that recovery.
- R11: An owed refresh is granted and performed before a pending self-refresh command is taken.
- R12: `addr` is zero whenever `ras_n` is high, and always zero in the CAS-before-RAS variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Access sequencer hands the strobe pins to this block |
| sr_req | input | 1 | Level command: enter and stay in self-refresh |
| ref_req | output | 1 | Request for the strobe pins |
| init_done | output | 1 | Power-up initialisation refreshes are complete |
| sr_active | output | 1 | DRAM is held in self-refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ROW_W | Row address for RAS-only refresh, zero otherwise |

## Verification
Every output is a function of registered state, so it answers a grant, an interval tick or a self-refresh level change at the first clock edge that samples it. The effect shows in the half cycle after that edge. The bench's behavioural model advances on the same edge as the design, and the outputs are compared at the falling edge that follows, so every value is checked in the cycle it is due. Strobe widths, the CAS lead before RAS, the start-up delay and the initialisation count are also measured directly from the pin waveforms, counted in whole cycles between edges.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_IDLE,
      ST_ARB,
      ST_LEAD,
      ST_STROBE,
      ST_PRE,
      ST_SR_HOLD,
      ST_SR_EXIT
   } rfsh_st_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rfsh_pace.sv
module rfsh_pace #(
   parameter int INIT_REFS = 8,
   parameter int IVL_CYC   = 1562,
   parameter int DEBT_MAX  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_done,
   input  logic sr_exit,
   output logic init_done,
   output logic owed
);
   localparam int IVL_W  = $clog2(IVL_CYC + 1);
   localparam int DEBT_W = $clog2(DEBT_MAX + 1);
   localparam int INIT_W = $clog2(INIT_REFS + 1);
   localparam logic [IVL_W-1:0]  IVL_LD   = IVL_W'(IVL_CYC - 1);
   localparam logic [DEBT_W-1:0] DEBT_TOP = DEBT_W'(DEBT_MAX);

   logic [IVL_W-1:0]  ivl_q;
   logic [DEBT_W-1:0] debt_q;
   logic [INIT_W-1:0] init_q;
   logic              tick;
   logic              paid;

   assign init_done = (init_q == '0);
   assign tick      = init_done && (ivl_q == '0);
   assign paid      = cyc_done && init_done;
   assign owed      = !init_done || (debt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= INIT_W'(INIT_REFS);
         ivl_q  <= IVL_LD;
         debt_q <= '0;
      end else begin
         if (cyc_done && !init_done)
            init_q <= init_q - 1'b1;
         if (init_done)
            ivl_q <= (ivl_q == '0) ? IVL_LD : ivl_q - 1'b1;
         if (sr_exit)
            debt_q <= '0;
         else if (tick && !paid) begin
            if (debt_q != DEBT_TOP)
               debt_q <= debt_q + 1'b1;
         end else if (!tick && paid)
            debt_q <= debt_q - 1'b1;
      end
   end
endmodule

// File: rtl/rfsh_rowgen.sv
module rfsh_rowgen #(
   parameter int ROW_W  = 11,
   parameter bit ENABLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [ROW_W-1:0] row
);
   generate
      if (ENABLE) begin : g_cnt
         logic [ROW_W-1:0] row_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               row_q <= '0;
            else if (step)
               row_q <= row_q + 1'b1;
         end
         assign row = row_q;
      end else begin : g_none
         logic unused_step;
         assign unused_step = step;
         assign row = '0;
      end
   endgenerate
endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched
   import dram_rfsh_pkg::*;
#(
   parameter bit RAS_ONLY      = 1'b0,
   parameter int ROW_W         = 11,
   parameter int CLK_MHZ       = 100,
   parameter int STARTUP_US    = 200,
   parameter int REF_PERIOD_US = 32000,
   parameter int INIT_REFS     = 8,
   parameter int DEBT_MAX      = 8,
   parameter int CSR_CYC       = 1,
   parameter int CHR_CYC       = 2,
   parameter int RAS_CYC       = 6,
   parameter int RP_CYC        = 5,
   parameter int RASS_CYC      = 10000,
   parameter int RPS_CYC       = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_gnt,
   input  logic             sr_req,
   output logic             ref_req,
   output logic             init_done,
   output logic             sr_active,
   output logic             ras_n,
   output logic             cas_n,
   output logic             we_n,
   output logic [ROW_W-1:0] addr
);
   localparam int STARTUP_CYC = STARTUP_US * CLK_MHZ;
   localparam int IVL_CYC     = (REF_PERIOD_US * CLK_MHZ) / (1 << ROW_W);
   localparam int TMAX        = imax(imax(STARTUP_CYC, RASS_CYC),
                                     imax(imax(RAS_CYC, RP_CYC), imax(CSR_CYC, RPS_CYC)));
   localparam int TMR_W       = $clog2(TMAX + 1);
   localparam logic [TMR_W-1:0] CAS_KEEP = TMR_W'(RAS_CYC - CHR_CYC);

   initial begin
      if (RAS_CYC <= CHR_CYC || CSR_CYC < 1 || RP_CYC < 1 || RPS_CYC < 1 ||
          RASS_CYC < 1 || STARTUP_CYC < 1 || IVL_CYC < 2 || DEBT_MAX < 1 ||
          INIT_REFS < 1 || ROW_W < 1)
         $fatal(1, "dram_rfsh_sched: inconsistent timing parameters");
   end

   rfsh_st_t         state;
   logic [TMR_W-1:0] tmr;
   logic             sr_kind;
   logic             owed;
   logic             cyc_done;
   logic             sr_exit;
   logic             row_step;
   logic [ROW_W-1:0] row;

   assign cyc_done = (state == ST_PRE) && (tmr == '0);
   assign sr_exit  = (state == ST_SR_EXIT) && (tmr == '0);
   assign row_step = (state == ST_STROBE) && (tmr == '0);

   rfsh_pace #(
      .INIT_REFS (INIT_REFS),
      .IVL_CYC   (IVL_CYC),
      .DEBT_MAX  (DEBT_MAX)
   ) pace_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_done  (cyc_done),
      .sr_exit   (sr_exit),
      .init_done (init_done),
      .owed      (owed)
   );

   rfsh_rowgen #(
      .ROW_W  (ROW_W),
      .ENABLE (RAS_ONLY)
   ) rowgen_i (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (row_step),
      .row   (row)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_BOOT;
         tmr     <= TMR_W'(STARTUP_CYC - 1);
         sr_kind <= 1'b0;
      end else begin
         case (state)
            ST_BOOT:
               if (tmr == '0) state <= ST_IDLE;
               else           tmr   <= tmr - 1'b1;
            ST_IDLE:
               if (owed) begin
                  state   <= ST_ARB;
                  sr_kind <= 1'b0;
               end else if (sr_req && init_done) begin
                  state   <= ST_ARB;
                  sr_kind <= 1'b1;
               end
            ST_ARB:
               if (ref_gnt) begin
                  if (sr_kind || !RAS_ONLY) begin
                     state <= ST_LEAD;
                     tmr   <= TMR_W'(CSR_CYC - 1);
                  end else begin
                     state <= ST_STROBE;
                     tmr   <= TMR_W'(RAS_CYC - 1);
                  end
               end
            ST_LEAD:
               if (tmr != '0)
                  tmr <= tmr - 1'b1;
               else if (sr_kind) begin
                  state <= ST_SR_HOLD;
                  tmr   <= TMR_W'(RASS_CYC - 1);
               end else begin
                  state <= ST_STROBE;
                  tmr   <= TMR_W'(RAS_CYC - 1);
               end
            ST_STROBE:
               if (tmr != '0) tmr <= tmr - 1'b1;
               else begin
                  state <= ST_PRE;
                  tmr   <= TMR_W'(RP_CYC - 1);
               end
            ST_PRE:
               if (tmr != '0) tmr   <= tmr - 1'b1;
               else           state <= ST_IDLE;
            ST_SR_HOLD:
               if (tmr != '0) tmr <= tmr - 1'b1;
               else if (!sr_req) begin
                  state <= ST_SR_EXIT;
                  tmr   <= TMR_W'(RPS_CYC - 1);
               end
            ST_SR_EXIT:
               if (tmr != '0) tmr   <= tmr - 1'b1;
               else           state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic strobe_cas;
   generate
      if (RAS_ONLY) begin : g_rasonly
         assign strobe_cas = 1'b0;
         assign addr       = (state == ST_STROBE) ? row : '0;
      end else begin : g_cbr
         assign strobe_cas = (state == ST_STROBE) && (tmr >= CAS_KEEP);
         assign addr       = row;
      end
   endgenerate

   assign ref_req   = (state == ST_ARB);
   assign sr_active = (state == ST_SR_HOLD);
   assign ras_n     = !((state == ST_STROBE) || (state == ST_SR_HOLD));
   assign cas_n     = !((state == ST_LEAD) || (state == ST_SR_HOLD) || strobe_cas);
   assign we_n      = 1'b1;
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
   parameter int ROW_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ref_req,
   input logic             ref_gnt,
   input logic             sr_active,
   input logic             ras_n,
   input logic             cas_n,
   input logic [ROW_W-1:0] addr
);
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && !ref_gnt) |=> ref_req);                            // R3
   AST_REQ_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |-> (ras_n && cas_n));                                 // R3
   AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && !cas_n) |-> $past(!cas_n));                   // R4
   AST_SR_STROBES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      sr_active |-> (!ras_n && !cas_n));                             // R9
   AST_SR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sr_active) |-> (ras_n && cas_n));                        // R10
   AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ras_n |-> (addr == '0));                                       // R12
endmodule

bind dram_rfsh_sched rfsh_sched_chk #(.ROW_W(ROW_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_req   (ref_req),
   .ref_gnt   (ref_gnt),
   .sr_active (sr_active),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .addr      (addr)
);

// File: tb/dram_rfsh_sched_tb_top.sv
module rfsh_ref_model #(
   parameter bit RAS_ONLY = 1'b0,
   parameter int BOOT = 50, parameter int IVL = 40, parameter int CSR = 2,
   parameter int CHR = 3, parameter int RAS = 5, parameter int RP = 3,
   parameter int RASS = 20, parameter int RPS = 4, parameter int INITN = 8,
   parameter int DMAX = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        gnt,
   input  logic        sr,
   output logic        e_req,
   output logic        e_init,
   output logic        e_sra,
   output logic        e_ras,
   output logic        e_cas,
   output logic        e_we,
   output logic [10:0] e_addr
);
   int ph = 0, cnt = BOOT - 1, initl = INITN, ivl = IVL - 1, debt = 0, row = 0;
   bit srk = 0;
   logic [13:0] q[$];

   initial begin
      e_req = 0; e_init = 0; e_sra = 0;
      e_ras = 1; e_cas = 1; e_we = 1; e_addr = '0;
   end

   always @(posedge clk) begin
      bit tick, done, sx, was_init;
      if (!rst_n) begin
         ph = 0; cnt = BOOT - 1; initl = INITN; ivl = IVL - 1;
         debt = 0; row = 0; srk = 0; q.delete();
      end else begin
         was_init = (initl == 0);
         tick = was_init && (ivl == 0);
         done = 0; sx = 0;
         case (ph)
            0: if (cnt == 0) ph = 1; else cnt--;
            1: if (initl != 0 || debt != 0) begin ph = 2; srk = 0; end
               else if (sr) begin ph = 2; srk = 1; end
            2: if (gnt) begin
                  ph = 3;
                  if (srk || !RAS_ONLY) repeat (CSR) q.push_back({3'b101, 11'd0});
                  if (!srk) begin
                     if (RAS_ONLY) begin
                        repeat (RAS) q.push_back({3'b011, 11'(row)});
                        row = (row + 1) % 2048;
                     end else begin
                        repeat (CHR) q.push_back({3'b001, 11'd0});
                        repeat (RAS - CHR) q.push_back({3'b011, 11'd0});
                     end
                     repeat (RP) q.push_back({3'b111, 11'd0});
                  end
               end
            3: begin
                  if (q.size() == 1) begin
                     if (srk) begin ph = 4; cnt = RASS - 1; end
                     else begin ph = 1; done = 1; end
                  end
                  void'(q.pop_front());
               end
            4: if (cnt != 0) cnt--; else if (!sr) begin ph = 5; cnt = RPS - 1; end
            5: if (cnt == 0) begin ph = 1; sx = 1; end else cnt--;
            default: ph = 1;
         endcase
         if (done && !was_init) initl--;
         if (was_init) ivl = (ivl == 0) ? IVL - 1 : ivl - 1;
         if (sx) debt = 0;
         else if (tick && !(done && was_init)) begin if (debt < DMAX) debt++; end
         else if (!tick && done && was_init) debt--;
      end
      e_req = (ph == 2);
      e_init = (initl == 0);
      e_sra = (ph == 4);
      if (ph == 3) {e_ras, e_cas, e_we, e_addr} = q[0];
      else if (ph == 4) {e_ras, e_cas, e_we, e_addr} = {3'b001, 11'd0};
      else {e_ras, e_cas, e_we, e_addr} = {3'b111, 11'd0};
   end
endmodule

module dram_rfsh_sched_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic clk = 0;
   logic rst_n = 0;
   logic gnt_a = 0, sr_a = 0, gnt_b = 0;

   logic req_a, init_a, sra_a, ras_a, cas_a, we_a;
   logic req_b, init_b, sra_b, ras_b, cas_b, we_b;
   logic [10:0] addr_a, addr_b;
   logic m_req_a, m_init_a, m_sra_a, m_ras_a, m_cas_a, m_we_a;
   logic m_req_b, m_init_b, m_sra_b, m_ras_b, m_cas_b, m_we_b;
   logic [10:0] m_addr_a, m_addr_b;

   int vectors = 0, errors = 0, cyc = 0;
   bit ended = 0;
   string tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_rfsh_sched #(
      .CLK_MHZ(1), .STARTUP_US(50), .REF_PERIOD_US(81920),
      .CSR_CYC(2), .CHR_CYC(3), .RAS_CYC(5), .RP_CYC(3), .RASS_CYC(20), .RPS_CYC(4)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ref_gnt(gnt_a), .sr_req(sr_a),
      .ref_req(req_a), .init_done(init_a), .sr_active(sra_a),
      .ras_n(ras_a), .cas_n(cas_a), .we_n(we_a), .addr(addr_a));

   dram_rfsh_sched #(
      .RAS_ONLY(1'b1), .CLK_MHZ(1), .STARTUP_US(50), .REF_PERIOD_US(28672),
      .CSR_CYC(2), .CHR_CYC(3), .RAS_CYC(5), .RP_CYC(3), .RASS_CYC(20), .RPS_CYC(4)
   ) dut_ro_i (
      .clk(clk), .rst_n(rst_n), .ref_gnt(gnt_b), .sr_req(1'b0),
      .ref_req(req_b), .init_done(init_b), .sr_active(sra_b),
      .ras_n(ras_b), .cas_n(cas_b), .we_n(we_b), .addr(addr_b));

   rfsh_ref_model #(.IVL(40)) mdl_a_i (
      .clk(clk), .rst_n(rst_n), .gnt(gnt_a), .sr(sr_a),
      .e_req(m_req_a), .e_init(m_init_a), .e_sra(m_sra_a),
      .e_ras(m_ras_a), .e_cas(m_cas_a), .e_we(m_we_a), .e_addr(m_addr_a));

   rfsh_ref_model #(.RAS_ONLY(1'b1), .IVL(14)) mdl_b_i (
      .clk(clk), .rst_n(rst_n), .gnt(gnt_b), .sr(1'b0),
      .e_req(m_req_b), .e_init(m_init_b), .e_sra(m_sra_b),
      .e_ras(m_ras_b), .e_cas(m_cas_b), .e_we(m_we_b), .e_addr(m_addr_b));

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // pin-level measurements on both instances
   int  cas_lead = 0, ras_len = 0, sr_len = 0, init_falls = 0, cas_ro_low = 0;
   int  first_req = -1, last_row = -1;
   bit  prev_ras_a = 1, prev_ras_b = 1, prev_init = 0, prev_sra = 0, saw_sr = 0, saw_wrap = 0;

   always @(negedge clk) begin
      if (rst_n) cyc++;
      check({req_a, init_a, sra_a, ras_a, cas_a, we_a, addr_a} ===
            {m_req_a, m_init_a, m_sra_a, m_ras_a, m_cas_a, m_we_a, m_addr_a},
            tag, "cbr pins",
            {req_a, init_a, sra_a, ras_a, cas_a, we_a, addr_a},
            {m_req_a, m_init_a, m_sra_a, m_ras_a, m_cas_a, m_we_a, m_addr_a});
      check({req_b, init_b, sra_b, ras_b, cas_b, we_b, addr_b} ===
            {m_req_b, m_init_b, m_sra_b, m_ras_b, m_cas_b, m_we_b, m_addr_b},
            "R7", "ras-only pins",
            {req_b, init_b, sra_b, ras_b, cas_b, we_b, addr_b},
            {m_req_b, m_init_b, m_sra_b, m_ras_b, m_cas_b, m_we_b, m_addr_b});
      if (rst_n) begin
         // R1: no request during start-up
         if (req_a && first_req < 0) begin
            first_req = cyc;
            check(cyc > 50, "R1", "first request cycle", cyc, 51);
         end
         // R2: init refresh count
         if (!ras_a && prev_ras_a && !init_a) init_falls++;
         if (init_a && !prev_init) check(init_falls == 8, "R2", "init refreshes", init_falls, 8);
         // R4: CAS lead and RAS width
         if (ras_a && !cas_a) cas_lead++;
         if (!ras_a && prev_ras_a) begin
            check(cas_lead == 2 && we_a, "R4", "cas lead before ras", cas_lead, 2);
         end
         if (ras_a) begin
            if (!prev_ras_a && !prev_sra) check(ras_len == 5, "R4", "ras low width", ras_len, 5);
            ras_len = 0;
         end else ras_len++;
         if (cas_a) cas_lead = 0;
         // R9: self-refresh hold length
         if (sra_a) begin sr_len++; saw_sr = 1; end
         else begin
            if (prev_sra) check(sr_len >= 20 && ras_a && cas_a, "R9", "self-refresh hold", sr_len, 20);
            sr_len = 0;
         end
         // R7 / R8: RAS-only variant
         if (!cas_b) cas_ro_low++;
         if (!ras_b && prev_ras_b) begin
            if (last_row == 2047 && addr_b == 0) saw_wrap = 1;
            if (last_row >= 0)
               check(addr_b == 11'((last_row + 1) % 2048), "R8", "row advance", addr_b, (last_row + 1) % 2048);
            last_row = addr_b;
         end
      end else begin
         check(ras_a && cas_a && we_a && !req_a && !init_a && addr_a == 0, "R1", "reset pins",
               {req_a, init_a, ras_a, cas_a, we_a}, 5'b00111);
      end
      prev_ras_a = ras_a; prev_ras_b = ras_b; prev_init = init_a; prev_sra = sra_a;
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      run(3);
      rst_n = 1; gnt_a = 1; gnt_b = 1;
      tag = "R2";  run(200);
      tag = "R5";  run(300);
      tag = "R3";
      for (int i = 0; i < 300; i++) begin gnt_a = (i % 8 == 0); run(1); end
      tag = "R6";  gnt_a = 0; run(480); gnt_a = 1; run(200);
      tag = "R9";  sr_a = 1; run(60); sr_a = 0; run(50);
      tag = "R11"; gnt_a = 0; run(90); sr_a = 1; gnt_a = 1; run(60); sr_a = 0; run(40);
      tag = "R10"; sr_a = 1; run(100); sr_a = 0; run(100);
      tag = "R12"; run(30000);
      check(saw_sr, "R9", "self-refresh entered", saw_sr, 1);
      check(cas_ro_low == 0, "R7", "cas low cycles in ras-only", cas_ro_low, 0);
      check(saw_wrap, "R8", "row wrap seen", saw_wrap, 1);
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!ended) begin
         ended = 1;
         vectors++; errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule